// File: doc/BRIEF.md
# USB Host Frame Timer and Root-Port Interrupt Status

This block keeps time for a USB host controller and collects its interrupt causes. A 14-bit down counter advances on each pulse of a 12 MHz enable input. When a frame's worth of ticks has elapsed, the counter reloads itself from a programmed reload value and emits a one-cycle frame pulse. The pulse also sets a sticky frame-expiry flag. After reset the reload value is 0x2EE0 (12000 ticks), which gives a 1 ms frame.

Two root ports are monitored. Each port's asynchronous SE0 line first passes through a synchronizer. A change of SE0 in either direction sets that port's connect-change flag, and the synchronized SE0 level can be read as a live status bit. A device that is present shows a live bit of 0; a device that has been removed shows 1. Each port also has a remote-wakeup event input. A single transfer-done flag records every completed handshake from either port, whatever its outcome.

Software uses a small register interface with three registers: the reload value, the status word and an interrupt enable mask. Flags are cleared by writing ones to them. The interrupt line is high whenever an enabled flag is set.

Top module: `hc_frame_irq`

## Requirements
- R1: After reset, the count register reads 0x2EE0, the mask register reads 0, the status register reads 0 (with both SE0 inputs low), and `irq` is 0.
- R2: `frame_tick` pulses once every N cycles in which `tick_en` is high, where N is the reload value (N = 0 behaves as 1). Cycles with `tick_en` low do not advance the counter.
- R3: The count register sits at address 0. A read returns the programmed reload value in bits [13:0] and zero in bits [15:14], whatever was written to those two bits.
- R4: Writing the count register does not change the frame in progress. The new value first governs the frame that follows the next reload.
- R5: Every `frame_tick` sets status bit 9.
- R6: Status bits 2 (port 0) and 3 (port 1) show the synchronized SE0 level. A rising or falling edge of that level sets bit 4 (port 0) or bit 5 (port 1).
- R7: A `wake_evt[p]` pulse sets status bit 6 for p = 0 and bit 7 for p = 1.
- R8: A `done_stb` pulse sets status bit 0 when `done_code` is 1 (device ACK), 2 (NAK), 3 (STALL), 4 (timeout) or 5 (host ACK). Codes 0, 6 and 7 are ignored.
- R9: The status register is at address 1. Writing a 1 to a flag bit clears that flag. Writing a 0 leaves it unchanged. Writes have no effect on the live SE0 bits.
- R10: If a flag is set and cleared in the same cycle, the set wins and the flag stays 1.
- R11: The mask register is at address 2 and holds only the implemented flag bits (0x02F1). `irq` is a register that becomes the OR of (flags AND mask) one cycle after they change.
- R12: `rvalid` pulses in the cycle after a `rd_en` cycle and carries the data for the address given. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 12 MHz count enable |
| se0_async | input | 2 | Asynchronous SE0 level per root port |
| wake_evt | input | 2 | Remote-wakeup event pulse per port |
| done_stb | input | 1 | Handshake-result strobe from the transfer engine |
| done_code | input | 3 | Handshake result qualifying `done_stb` |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | Read data valid |
| irq | output | 1 | Masked interrupt request |
| frame_tick | output | 1 | One-cycle pulse at each frame boundary |

## Verification
A software clear and a hardware event can land on the same flag in the same clock cycle. The bench provokes this by issuing a write-one-to-clear of the wakeup flag in the very cycle that a wakeup pulse arrives, and again for the done flag together with a done strobe. The status read that follows must still show the flag set. A second overlap is a reload-value write while a frame is running. It is judged from the spacing of `frame_tick` pulses: the frame in progress keeps its old length, and only the frames after it take the new one.

// File: rtl/hcfi_pkg.sv
package hcfi_pkg;
  localparam int DW    = 16;
  localparam int CW    = 14;
  localparam int NPORT = 2;

  // status bit positions (software visible)
  localparam int B_DONE = 0;
  localparam int B_SE0  = 2;  // + port
  localparam int B_CC   = 4;  // + port
  localparam int B_WAKE = 6;  // + port
  localparam int B_SOF  = 9;

  localparam logic [DW-1:0] FLAG_BITS = 16'h02F1;

  typedef enum logic [1:0] {
    RA_COUNT = 2'd0,
    RA_STAT  = 2'd1,
    RA_MASK  = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    HS_IDLE    = 3'd0,
    HS_DEV_ACK = 3'd1,
    HS_NAK     = 3'd2,
    HS_STALL   = 3'd3,
    HS_TMO     = 3'd4,
    HS_HST_ACK = 3'd5
  } hs_code_e;
endpackage

// File: rtl/hcfi_frame_ctr.sv
module hcfi_frame_ctr #(
  parameter int CW = 14,
  parameter logic [CW-1:0] INIT_LOAD = 14'h2EE0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic [CW-1:0] reload,
  output logic          frame_tick
);
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= INIT_LOAD;
      frame_tick <= 1'b0;
    end else begin
      frame_tick <= tick_en && last;
      if (tick_en) cnt <= last ? reload : cnt - CW'(1);
    end
  end

  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    frame_tick |-> $past(tick_en)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt)); // R2
endmodule

// File: rtl/hcfi_port_mon.sv
module hcfi_port_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic se0_async,
  output logic se0_live,
  output logic se0_edge
);
  logic [SYNC:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], se0_async};
  end

  assign se0_live = sh[SYNC-1];
  assign se0_edge = sh[SYNC-1] ^ sh[SYNC];
endmodule

// File: rtl/hcfi_status.sv
module hcfi_status #(
  parameter int DW = 16,
  parameter logic [DW-1:0] IMPL = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  output logic [DW-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= ((flags & ~clr_vec) | set_vec) & IMPL;
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(flags) & ~$past(clr_vec)) & ~flags) == '0)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(set_vec) & IMPL) & ~flags) == '0)); // R10
endmodule

// File: rtl/hc_frame_irq.sv
module hc_frame_irq
  import hcfi_pkg::*;
#(
  parameter logic [CW-1:0] INIT_LOAD = 14'h2EE0,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [NPORT-1:0] se0_async,
  input  logic [NPORT-1:0] wake_evt,
  input  logic             done_stb,
  input  logic [2:0]       done_code,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic             irq,
  output logic             frame_tick
);
  logic [CW-1:0]    reload_q;
  logic [DW-1:0]    mask_q;
  logic [DW-1:0]    flags;
  logic [DW-1:0]    set_vec;
  logic [DW-1:0]    clr_vec;
  logic [DW-1:0]    stat_view;
  logic [NPORT-1:0] se0_live;
  logic [NPORT-1:0] se0_edge;
  logic             done_ok;
  reg_addr_e        ra;

  assign ra = reg_addr_e'(addr);

  hcfi_frame_ctr #(.CW(CW), .INIT_LOAD(INIT_LOAD)) u_frm (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .reload(reload_q), .frame_tick(frame_tick)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    hcfi_port_mon #(.SYNC(SYNC)) u_mon (
      .clk(clk), .rst(rst), .se0_async(se0_async[p]),
      .se0_live(se0_live[p]), .se0_edge(se0_edge[p])
    );
  end

  always_comb begin
    unique case (hs_code_e'(done_code))
      HS_DEV_ACK, HS_NAK, HS_STALL, HS_TMO, HS_HST_ACK: done_ok = 1'b1;
      default: done_ok = 1'b0;
    endcase
  end

  always_comb begin
    set_vec = '0;
    set_vec[B_DONE] = done_stb && done_ok;
    set_vec[B_SOF]  = frame_tick;
    for (int p = 0; p < NPORT; p++) begin
      set_vec[B_CC + p]   = se0_edge[p];
      set_vec[B_WAKE + p] = wake_evt[p];
    end
    clr_vec = (wr_en && ra == RA_STAT) ? wdata : '0;
    stat_view = flags;
    for (int p = 0; p < NPORT; p++) stat_view[B_SE0 + p] = se0_live[p];
  end

  hcfi_status #(.DW(DW), .IMPL(FLAG_BITS)) u_stat (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= INIT_LOAD;
      mask_q   <= '0;
    end else if (wr_en) begin
      if (ra == RA_COUNT) reload_q <= wdata[CW-1:0];
      if (ra == RA_MASK)  mask_q   <= wdata & FLAG_BITS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      irq    <= 1'b0;
    end else begin
      rvalid <= rd_en;
      irq    <= |(flags & mask_q);
      if (rd_en) begin
        unique case (ra)
          RA_COUNT: rdata <= {{(DW-CW){1'b0}}, reload_q};
          RA_STAT:  rdata <= stat_view;
          RA_MASK:  rdata <= mask_q;
          default:  rdata <= '0;
        endcase
      end
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ra == RA_COUNT) |=> (rdata[DW-1:CW] == '0)); // R3
  AST_SOF_FLAG: assert property (@(posedge clk) disable iff (rst)
    frame_tick |=> flags[B_SOF]); // R5
  AST_CC_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (se0_live[0] != $past(se0_live[0])) |=> flags[B_CC]); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq); // R11
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_en)); // R12
endmodule

// File: tb/sim_hc_frame_irq.sv
module sim_hc_frame_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en;
  logic [1:0]  se0_async = '0;
  logic [1:0]  wake_evt = '0;
  logic        done_stb = 1'b0;
  logic [2:0]  done_code = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid;
  logic        irq;
  logic        frame_tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rel_cyc = 0;
  int ft_n = 0;
  int ft_first = 0;
  int ft_last = 0;
  int tick_mode = 0;  // 0 on, 1 alternate, 2 off
  int gap_q[$];
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  hc_frame_irq u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .se0_async(se0_async),
    .wake_evt(wake_evt), .done_stb(done_stb), .done_code(done_code),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .irq(irq), .frame_tick(frame_tick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial tick_en = 1'b1;
  always @(negedge clk) begin
    if (tick_mode == 1)      tick_en <= ~tick_en;
    else if (tick_mode == 2) tick_en <= 1'b0;
    else                     tick_en <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read results
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected rvalid", 1, 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata == e, t, rdata, e);
      end
    end
  end

  // frame monitor
  always @(negedge clk) begin
    if (frame_tick) begin
      if (ft_n > 0) gap_q.push_back(cyc - ft_last);
      else          ft_first = cyc;
      ft_last = cyc;
      ft_n++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done_pulse(input logic [2:0] c);
    @(negedge clk); done_stb = 1'b1; done_code = c;
    @(negedge clk); done_stb = 1'b0; done_code = '0;
  endtask

  task automatic wake_pulse(input logic [1:0] w);
    @(negedge clk); wake_evt = w;
    @(negedge clk); wake_evt = '0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst = 1'b0; rel_cyc = cyc;
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    rd(2'd0, 16'h2EE0, "R1 count reset");
    rd(2'd1, 16'h0000, "R1 status reset");
    rd(2'd2, 16'h0000, "R1 mask reset");

    // R3 / R4: reserved bits dropped, running frame untouched
    wr(2'd0, 16'hC00A);
    rd(2'd0, 16'h000A, "R3 count readback");
    wait (ft_n >= 3);
    chk((ft_first - rel_cyc) >= 11997 && (ft_first - rel_cyc) <= 12003,
        "R4 first frame keeps old length", ft_first - rel_cyc, 12000);
    chk(gap_q[0] == 10, "R2 frame gap after reload", gap_q[0], 10);
    chk(gap_q[1] == 10, "R2 steady frame gap", gap_q[1], 10);

    // R2: enable gating
    tick_mode = 1;
    wait (ft_n >= 6);
    chk(gap_q[4] == 20, "R2 half-rate gap", gap_q[4], 20);
    tick_mode = 2;
    n0 = ft_n;
    idle(60);
    chk(ft_n == n0, "R2 no tick while disabled", ft_n, n0);
    tick_mode = 0;
    wr(2'd0, 16'h3FFF);
    wait (ft_n >= n0 + 1);
    idle(2);
    rd(2'd1, 16'h0200, "R5 frame flag set");
    wr(2'd1, 16'h0200);
    rd(2'd1, 16'h0000, "R9 frame flag cleared");

    // R6 port 0
    @(negedge clk); se0_async[0] = 1'b1;
    idle(5);
    rd(2'd1, 16'h0014, "R6 port0 SE0 rise");
    wr(2'd1, 16'h0000);
    rd(2'd1, 16'h0014, "R9 zero write keeps flags");
    wr(2'd1, 16'h001C);
    rd(2'd1, 16'h0004, "R9 clear keeps live bit");
    @(negedge clk); se0_async[0] = 1'b0;
    idle(5);
    rd(2'd1, 16'h0010, "R6 port0 SE0 fall");
    wr(2'd1, 16'h0010);
    // R6 port 1
    @(negedge clk); se0_async[1] = 1'b1;
    idle(5);
    rd(2'd1, 16'h0028, "R6 port1 SE0 rise");
    wr(2'd1, 16'h0020);
    @(negedge clk); se0_async[1] = 1'b0;
    idle(5);
    rd(2'd1, 16'h0020, "R6 port1 SE0 fall");
    wr(2'd1, 16'h0020);
    rd(2'd1, 16'h0000, "R9 port1 cleared");

    // R7
    wake_pulse(2'b01);
    rd(2'd1, 16'h0040, "R7 wake port0");
    wake_pulse(2'b10);
    rd(2'd1, 16'h00C0, "R7 wake port1");
    wr(2'd1, 16'h00C0);

    // R8
    done_pulse(3'd0);
    done_pulse(3'd6);
    done_pulse(3'd7);
    rd(2'd1, 16'h0000, "R8 invalid codes ignored");
    done_pulse(3'd3);
    rd(2'd1, 16'h0001, "R8 stall sets done");
    wr(2'd1, 16'h0001);
    done_pulse(3'd5);
    rd(2'd1, 16'h0001, "R8 host ack sets done");
    wr(2'd1, 16'h0001);

    // R10: set and clear in the same cycle
    @(negedge clk); wr_en = 1'b1; addr = 2'd1; wdata = 16'h0040; wake_evt = 2'b01;
    @(negedge clk); wr_en = 1'b0; wake_evt = 2'b00;
    rd(2'd1, 16'h0040, "R10 wake set beats clear");
    @(negedge clk); wr_en = 1'b1; addr = 2'd1; wdata = 16'h0041;
    done_stb = 1'b1; done_code = 3'd2;
    @(negedge clk); wr_en = 1'b0; done_stb = 1'b0; done_code = '0;
    rd(2'd1, 16'h0001, "R10 done set beats clear");
    wr(2'd1, 16'h0001);

    // R11
    wr(2'd2, 16'hFFFF);
    rd(2'd2, 16'h02F1, "R11 mask implemented bits");
    wr(2'd2, 16'h0041);
    idle(2);
    chk(irq == 1'b0, "R11 irq idle", irq, 0);
    wake_pulse(2'b10);
    idle(2);
    chk(irq == 1'b0, "R11 unmasked flag no irq", irq, 0);
    done_pulse(3'd1);
    idle(2);
    chk(irq == 1'b1, "R11 masked flag raises irq", irq, 1);
    wr(2'd1, 16'h0001);
    idle(2);
    chk(irq == 1'b0, "R11 irq drops after clear", irq, 0);

    // R12
    rd(2'd3, 16'h0000, "R12 unused address");
    idle(3);
    chk(exp_q.size() == 0, "R12 all reads answered", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule